// File: doc/BRIEF.md
# SPI Receive Slave with Wake Qualification

This block receives 8-bit words from an external SPI master. The master drives serial clock, data and an active-low select, and the block samples them in its own clock domain. Each completed word raises a word-ready flag. A word that completes while the previous one is still unread raises an overrun flag. Driving the select low while the block is set up as a master raises a mode-fault flag. The three flags share one interrupt request, which is gated by an enable bit and by a global mask input.

A simple power controller tells the block whether the device is in a wait state or a halt state. From these inputs the block decides whether the pending interrupt may raise its wake request.

- In wait, any interrupt the gating lets through wakes the device.
- In halt, only the word-ready flag can wake the device, and only if the effective select was low when halt began.
- Leaving halt while still a slave puts the block into a recovery state. The next word it receives only ends that state and is otherwise discarded.

Top module: `spi_wake_slave`

## Requirements
- R1: Bits are sampled on rising serial clock edges while the effective select is low, the slave is enabled and master mode is off, most significant bit first. When the eighth bit arrives, that word is loaded into `rx_data` and `flag_done` is set.
- R2: When a word completes while `flag_done` is already set, `flag_ovr` is set and `rx_data` keeps the earlier, unread word.
- R3: A `rd_status` pulse seen while `flag_done` or `flag_ovr` is set, followed by a `rd_data` pulse, clears both flags. A `rd_data` pulse with no such status read before it leaves both flags set.
- R4: `flag_mf` sets while `cfg_master` is 1 and the synchronized `ss_n` pin is low. It clears only on a `wr_ctrl` pulse that follows a `rd_status` pulse taken while it was set. A `wr_ctrl` pulse alone leaves it set.
- R5: `irq` equals (`flag_done` or `flag_ovr` or `flag_mf`) gated by `cfg_irq_en`=1 and `irq_mask`=0.
- R6: While `pwr_wait` is 1, `wake` follows `irq` for any flag source, including mode fault.
- R7: While `pwr_halt` is 1, `wake` is raised only by `flag_done` with `cfg_irq_en`=1 and `irq_mask`=0. A pending mode fault alone gives `wake`=0.
- R8: Halt wake is allowed only if the effective select was low on the cycle `pwr_halt` rose. The effective select is `ss_n` when `cfg_ss_soft_sel`=0 and `cfg_ss_level` when `cfg_ss_soft_sel`=1.
- R9: When `pwr_halt` falls with `cfg_slave_en`=1, `recovering` goes to 1. The next completed word then clears `recovering`, does not load `rx_data` and does not touch any flag.
- R10: `cfg_slave_en`=0 clears `recovering` on the next clock edge, with no recovery word needed.
- R11: After reset, all flags, `irq`, `wake`, `recovering` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Select pin, active low |
| cfg_slave_en | input | 1 | Enables the slave function |
| cfg_master | input | 1 | Master configuration (stops reception, arms mode-fault detection) |
| cfg_ss_soft_sel | input | 1 | 1 selects the internal select level instead of the pin |
| cfg_ss_level | input | 1 | Internal select level |
| cfg_irq_en | input | 1 | Interrupt enable |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| wr_ctrl | input | 1 | Control write strobe |
| pwr_wait | input | 1 | Device is in the wait state |
| pwr_halt | input | 1 | Device is in the halt state |
| rx_data | output | 8 | Last accepted word |
| flag_done | output | 1 | Word-ready flag |
| flag_ovr | output | 1 | Overrun flag |
| flag_mf | output | 1 | Mode-fault flag |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake request to the power controller |
| recovering | output | 1 | Post-halt recovery state |

## Verification
The bench sends a second word while the first is unread. A design that overwrote the data register there would expose the newer byte instead of the older one.

It also tries the two-step clear sequences with a step missing. A design that cleared a flag on the second access alone would be caught.

In halt, the bench pends a mode fault and checks that `wake` stays low. It also enters halt with the select high and then receives a word; a design that checked the select level at wake time rather than at halt entry would wake wrongly there.

After a halt exit, the bench confirms that the first word is thrown away and the second is accepted. It also checks that turning off slave mode ends recovery at once.

// File: rtl/spi_wake_slave.sv
module spi_wake_slave #(
  parameter int W = 8,
  parameter int S = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         mosi,
  input  logic         ss_n,
  input  logic         cfg_slave_en,
  input  logic         cfg_master,
  input  logic         cfg_ss_soft_sel,
  input  logic         cfg_ss_level,
  input  logic         cfg_irq_en,
  input  logic         irq_mask,
  input  logic         rd_status,
  input  logic         rd_data,
  input  logic         wr_ctrl,
  input  logic         pwr_wait,
  input  logic         pwr_halt,
  output logic [W-1:0] rx_data,
  output logic         flag_done,
  output logic         flag_ovr,
  output logic         flag_mf,
  output logic         irq,
  output logic         wake,
  output logic         recovering
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [S:0]    sclk_p;
  logic [S-1:0]  mosi_p, ss_p;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          arm_rx, arm_mf, halt_q, halt_ok;

  wire ss_pin    = ss_p[S-1];
  wire ss_eff    = cfg_ss_soft_sel ? cfg_ss_level : ss_pin;
  wire rx_active = cfg_slave_en & ~cfg_master & ~ss_eff;
  wire sclk_rise = sclk_p[S-1] & ~sclk_p[S];
  wire last_bit  = (cnt == CW'(W-1));
  wire byte_end  = rx_active & sclk_rise & last_bit;
  wire [W-1:0] next_word = {sh[W-2:0], mosi_p[S-1]};
  wire accept    = byte_end & ~recovering;
  wire clr_rx    = rd_data & arm_rx;
  wire set_done  = accept & (~flag_done | clr_rx);
  wire set_ovr   = accept & flag_done & ~clr_rx;
  wire set_mf    = cfg_master & ~ss_pin;
  wire gate      = cfg_irq_en & ~irq_mask;
  wire halt_in   = pwr_halt & ~halt_q;
  wire halt_out  = ~pwr_halt & halt_q;

  assign irq  = gate & (flag_done | flag_ovr | flag_mf);
  assign wake = (pwr_wait & irq) | (pwr_halt & halt_ok & gate & flag_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      mosi_p <= '0;
      ss_p   <= '1;
    end else begin
      sclk_p <= {sclk_p[S-1:0], sclk};
      mosi_p <= {mosi_p[S-2:0], mosi};
      ss_p   <= {ss_p[S-2:0], ss_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (!rx_active) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      cnt <= last_bit ? '0 : cnt + 1'b1;
      sh  <= next_word;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data   <= '0;
      flag_done <= 1'b0;
      flag_ovr  <= 1'b0;
      arm_rx    <= 1'b0;
    end else begin
      if (set_done) begin
        rx_data   <= next_word;
        flag_done <= 1'b1;
      end else if (clr_rx) begin
        flag_done <= 1'b0;
      end
      if (set_ovr)     flag_ovr <= 1'b1;
      else if (clr_rx) flag_ovr <= 1'b0;
      if (rd_status && (flag_done || flag_ovr)) arm_rx <= 1'b1;
      else if (rd_data)                         arm_rx <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_mf <= 1'b0;
      arm_mf  <= 1'b0;
    end else begin
      if (set_mf) flag_mf <= 1'b1;
      else if (wr_ctrl && arm_mf) flag_mf <= 1'b0;
      if (rd_status && flag_mf) arm_mf <= 1'b1;
      else if (wr_ctrl)         arm_mf <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      halt_q     <= 1'b0;
      halt_ok    <= 1'b0;
      recovering <= 1'b0;
    end else begin
      halt_q <= pwr_halt;
      if (halt_in) halt_ok <= ~ss_eff;
      if (!cfg_slave_en)  recovering <= 1'b0;
      else if (halt_out)  recovering <= 1'b1;
      else if (byte_end)  recovering <= 1'b0;
    end
endmodule

module spi_wake_slave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_slave_en,
  input logic         cfg_irq_en,
  input logic         irq_mask,
  input logic         pwr_wait,
  input logic         pwr_halt,
  input logic [W-1:0] rx_data,
  input logic         flag_done,
  input logic         flag_ovr,
  input logic         irq,
  input logic         wake,
  input logic         recovering
);
  // R2
  ovr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> $past(flag_done));
  // R2
  data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> !$past(flag_done) || !$past(recovering) && $rose(flag_done));
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_irq_en && !irq_mask);
  // R6
  wait_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_wait && irq |-> wake);
  // R7
  halt_wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_halt && !pwr_wait && wake |-> flag_done);
  // R10
  recover_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_slave_en |=> !recovering);
endmodule

bind spi_wake_slave spi_wake_slave_chk #(.W(W)) u_chk (.*);

// File: tb/spi_wake_slave_tb.sv
module spi_wake_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 0, mosi = 0, ss_n = 1;
  logic cfg_slave_en = 0, cfg_master = 0, cfg_ss_soft_sel = 0, cfg_ss_level = 1;
  logic cfg_irq_en = 0, irq_mask = 1, rd_status = 0, rd_data = 0, wr_ctrl = 0;
  logic pwr_wait = 0, pwr_halt = 0;
  logic [7:0] rx_data;
  logic flag_done, flag_ovr, flag_mf, irq, wake, recovering;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_wake_slave u_dut (.*);

  // byte, clear-after, expected data, expected done, expected ovr
  localparam logic [18:0] VEC [4] = '{
    {8'hA5, 1'b0, 8'hA5, 1'b1, 1'b0},
    {8'h3C, 1'b1, 8'hA5, 1'b1, 1'b1},
    {8'h81, 1'b1, 8'h81, 1'b1, 1'b0},
    {8'h7E, 1'b0, 8'h7E, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i]; tick(4);
      sclk = 1;    tick(4);
      sclk = 0;
    end
    tick(6);
  endtask

  task automatic pulse_status(); rd_status = 1; tick(1); rd_status = 0; tick(1); endtask
  task automatic pulse_data();   rd_data = 1;   tick(1); rd_data = 0;   tick(1); endtask
  task automatic pulse_ctrl();   wr_ctrl = 1;   tick(1); wr_ctrl = 0;   tick(1); endtask
  task automatic clear_rx();     pulse_status(); pulse_data(); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R11 reset state
    chk("R11 done", flag_done, 0); chk("R11 ovr", flag_ovr, 0); chk("R11 mf", flag_mf, 0);
    chk("R11 irq", irq, 0); chk("R11 wake", wake, 0); chk("R11 rec", recovering, 0);
    chk("R11 data", rx_data, 0);
    rst_n = 1; tick(2);
    cfg_slave_en = 1; ss_n = 0; tick(4);

    // R1 R2 R3 vector walk
    foreach (VEC[i]) begin
      send(VEC[i][18:11]);
      chk("R1 data", rx_data, VEC[i][9:2]);
      chk("R1 done", flag_done, VEC[i][1]);
      chk("R2 ovr", flag_ovr, VEC[i][0]);
      if (VEC[i][10]) begin
        clear_rx();
        chk("R3 done clr", flag_done, 0); chk("R3 ovr clr", flag_ovr, 0);
      end
    end
    clear_rx();

    // R3 data read alone keeps flags
    send(8'h5A);
    pulse_data();
    chk("R3 no-arm", flag_done, 1);
    clear_rx();
    chk("R3 armed", flag_done, 0);

    // R5 gating
    cfg_irq_en = 1; irq_mask = 1;
    send(8'h0F);
    chk("R5 masked", irq, 0);
    irq_mask = 0; tick(1);
    chk("R5 open", irq, 1);
    cfg_irq_en = 0; tick(1);
    chk("R5 disabled", irq, 0);
    cfg_irq_en = 1;
    clear_rx();

    // R4 R6 R7 mode fault
    cfg_slave_en = 0; cfg_master = 1; ss_n = 0; tick(5);
    chk("R4 set", flag_mf, 1);
    pwr_wait = 1; tick(1);
    chk("R6 wake mf", wake, 1);
    pwr_wait = 0; pwr_halt = 1; tick(3);
    chk("R7 mf no halt wake", wake, 0);
    pwr_halt = 0; ss_n = 1; tick(5);
    pulse_ctrl();
    chk("R4 ctrl alone", flag_mf, 1);
    pulse_status(); pulse_ctrl();
    chk("R4 cleared", flag_mf, 0);
    cfg_master = 0;

    // R7 R8 R9 halt wake and recovery
    cfg_slave_en = 1; ss_n = 0; tick(5);
    pwr_halt = 1; tick(2);
    send(8'hA3);
    chk("R7 halt wake", wake, 1);
    chk("R1 halt data", rx_data, 8'hA3);
    pwr_halt = 0; tick(3);
    chk("R9 rec set", recovering, 1);
    clear_rx();
    send(8'h11);
    chk("R9 discard done", flag_done, 0);
    chk("R9 discard data", rx_data, 8'hA3);
    chk("R9 rec end", recovering, 0);
    send(8'h22);
    chk("R9 normal", rx_data, 8'h22);
    clear_rx();

    // R8 select high at halt entry
    ss_n = 1; tick(5);
    pwr_halt = 1; tick(2);
    ss_n = 0; tick(5);
    send(8'h44);
    chk("R8 done", flag_done, 1);
    chk("R8 no wake", wake, 0);
    clear_rx();
    pwr_halt = 0; tick(3);
    chk("R9 rec again", recovering, 1);
    // R10
    cfg_slave_en = 0; tick(1);
    chk("R10 rec drop", recovering, 0);

    // R8 soft select
    cfg_slave_en = 1; cfg_ss_soft_sel = 1; cfg_ss_level = 0; ss_n = 1; tick(5);
    pwr_halt = 1; tick(2);
    send(8'h66);
    chk("R8 soft data", rx_data, 8'h66);
    chk("R8 soft wake", wake, 1);
    cfg_slave_en = 0; tick(1);
    pwr_halt = 0; tick(3);
    chk("R10 no rec", recovering, 0);
    finish_run();
  end
endmodule